// File: doc/BRIEF.md
# Prioritised Multi-Source Interrupt Controller

This block gathers 27 interrupt sources from four groups and turns them into one prioritised request for a processor. The groups are seven backplane request lines, seven local lines, five error and status events and eight interprocessor switch events. The error and status events include AC failure, system failure, a posted write that ended in a bus error, DMA completion and an arbitration timeout. Every source has its own 3-bit priority level and its own mask bit. The highest unmasked pending level appears on a 3-bit active-low request code. Level 7 is the most urgent, and all ones means that nothing is requesting.

When the processor acknowledges a level, it pulses an acknowledge strobe together with that level. One cycle later the block returns the winning source index. It also returns an 8-bit status/ID vector whenever the controller supplies that vector itself. For an edge-latched winner, the acknowledge also clears the latch. Each local line is configured separately for polarity, for edge or level sensitivity, and for whether the controller supplies its vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `ipl_n` equals the bitwise inverse of the highest level among unmasked pending sources, and 3'b111 when there are none. It is valid in the cycle after the input edge that made a source pending. A source with level 0 never requests.
- R2: A source whose `src_mask` bit is 1 never contributes to `ipl_n` and is never chosen on acknowledge. The mask acts without delay on pending state.
- R3: The global source index is: error/status events 0-4, interprocessor events 5-12, local lines 13-19, backplane lines 20-26. Within one level, the lowest global index wins.
- R4: Error/status events, interprocessor events and local lines in edge mode (`loc_edge`=1) latch on the rising edge of their active signal. They stay pending after the input returns to idle.
- R5: Backplane lines (active low, `bp_irq_n`) and local lines in level mode are pending exactly while their active signal is asserted.
- R6: A local line is active-high (rising edge) when `loc_pol`=1 and active-low (falling edge) when `loc_pol`=0.
- R7: A cycle with `iack`=1 gives `ack_valid`=1 in the following cycle, with `ack_src` set to the winning index at level `iack_lvl`. That acknowledge clears an edge-latched winner. `ack_valid` is 0 in every cycle that does not follow an `iack` cycle.
- R8: When no unmasked source is pending at the acknowledged level, or that level is 0, the response carries `ack_none`=1, `ack_src`=0, `ack_own`=0 and `ack_vec`=0.
- R9: For an error or interprocessor winner, the response gives `ack_own`=1 and `ack_vec`={`int_vec_base`, 5-bit index}. For a local winner k with `loc_vec_en[k]`=1, it gives `ack_own`=1 and `ack_vec`=`loc_vec[8k+7:8k]`. For a backplane winner or any other local winner, it gives `ack_own`=0 and `ack_vec`=0.
- R10: A 1 on `src_clr[i]` clears the latched pending state of edge source i at the next clock edge.
- R11: After synchronous reset, `ipl_n` is 3'b111 and `ack_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bp_irq_n | input | 7 | Backplane request lines, active low, level |
| loc_irq | input | 7 | Local interrupt lines, raw |
| err_evt | input | 5 | Error/status events, rising-edge |
| ipc_evt | input | 8 | Interprocessor switch events, rising-edge |
| loc_edge | input | 7 | Per local line: 1 edge, 0 level |
| loc_pol | input | 7 | Per local line: 1 high/rising, 0 low/falling |
| loc_vec_en | input | 7 | Per local line: controller supplies vector |
| loc_vec | input | 56 | Per local line 8-bit vector, line k at [8k+7:8k] |
| int_vec_base | input | 3 | Upper vector bits for error and interprocessor sources |
| src_lvl | input | 81 | Priority level per source, index i at [3i+2:3i] |
| src_mask | input | 27 | Per-source mask |
| src_clr | input | 27 | Per-source latch clear |
| iack | input | 1 | Acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| ipl_n | output | 3 | Encoded request level, active low |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_none | output | 1 | No source pending at the acknowledged level |
| ack_src | output | 5 | Winning global source index |
| ack_own | output | 1 | Vector supplied by the controller |
| ack_vec | output | 8 | Status/ID vector |

## Verification
The bench builds the block with its default group sizes of 7, 7, 5 and 8 and 3-bit levels. With these sizes, all 27 global indices and every group boundary can be reached. That puts ties between groups at one level (interprocessor against local against backplane) within reach. It also covers the edge between the controller-supplied internal vectors and the local vectors. Falling-edge and active-low local lines, explicit clears and acknowledges at empty levels are all driven through the same configuration.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/100ps
package irq_prio_pkg;
    localparam int N_ERR  = 5;
    localparam int N_IPC  = 8;
    localparam int N_LOC  = 7;
    localparam int N_BP   = 7;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int N_SRC  = N_ERR + N_IPC + N_LOC + N_BP;
    localparam int SRC_W  = $clog2(N_SRC);
    localparam int IPC_B  = N_ERR;
    localparam int LOC_B  = IPC_B + N_IPC;
    localparam int BP_B   = LOC_B + N_LOC;

    typedef enum logic [1:0] {GRP_ERR, GRP_IPC, GRP_LOC, GRP_BP} grp_e;

    function automatic grp_e grp_of(input int idx);
        if (idx < IPC_B)      return GRP_ERR;
        else if (idx < LOC_B) return GRP_IPC;
        else if (idx < BP_B)  return GRP_LOC;
        else                  return GRP_BP;
    endfunction

    typedef struct packed {
        logic                none;
        logic [SRC_W-1:0]    src;
        logic                own;
        logic [VEC_W-1:0]    vec;
    } ack_rsp_t;
endpackage

// File: rtl/irq_src_cond.sv
`timescale 1ns/100ps
module irq_src_cond (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic pol,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic act;
    logic act_q;
    logic rise;

    assign act  = pol ? raw : ~raw;
    assign rise = act & ~act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            act_q <= act;
            if (edge_mode)
                pend <= rise | (pend & ~clr);
            else
                pend <= act;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/100ps
module irq_prio_sel #(
    parameter int N     = 27,
    parameter int LW    = 3,
    parameter int IW    = 5
) (
    input  logic [N-1:0]    req,
    input  logic [N*LW-1:0] lvl,
    input  logic [LW-1:0]   sel_lvl,
    output logic [LW-1:0]   top_lvl,
    output logic            hit,
    output logic [IW-1:0]   hit_idx
);
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl[i*LW +: LW] > top_lvl))
                top_lvl = lvl[i*LW +: LW];
        end
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (req[i] && (sel_lvl != '0) && (lvl[i*LW +: LW] == sel_lvl)) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/100ps
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_BP-1:0]        bp_irq_n,
    input  logic [N_LOC-1:0]       loc_irq,
    input  logic [N_ERR-1:0]       err_evt,
    input  logic [N_IPC-1:0]       ipc_evt,
    input  logic [N_LOC-1:0]       loc_edge,
    input  logic [N_LOC-1:0]       loc_pol,
    input  logic [N_LOC-1:0]       loc_vec_en,
    input  logic [N_LOC*VEC_W-1:0] loc_vec,
    input  logic [VEC_W-SRC_W-1:0] int_vec_base,
    input  logic [N_SRC*LVL_W-1:0] src_lvl,
    input  logic [N_SRC-1:0]       src_mask,
    input  logic [N_SRC-1:0]       src_clr,
    input  logic                   iack,
    input  logic [LVL_W-1:0]       iack_lvl,
    output logic [LVL_W-1:0]       ipl_n,
    output logic                   ack_valid,
    output logic                   ack_none,
    output logic [SRC_W-1:0]       ack_src,
    output logic                   ack_own,
    output logic [VEC_W-1:0]       ack_vec
);
    logic [N_SRC-1:0] raw_v, pol_v, edge_v, clr_v, pend_v, eff_v, ack_clr;
    logic [LVL_W-1:0] top_lvl;
    logic             hit;
    logic [SRC_W-1:0] hit_idx;
    ack_rsp_t         rsp_d, rsp_q;
    logic             valid_q;

    // map each group onto the global index space
    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_map
            if (i < IPC_B) begin : g_err
                assign raw_v[i]  = err_evt[i];
                assign pol_v[i]  = 1'b1;
                assign edge_v[i] = 1'b1;
            end else if (i < LOC_B) begin : g_ipc
                assign raw_v[i]  = ipc_evt[i-IPC_B];
                assign pol_v[i]  = 1'b1;
                assign edge_v[i] = 1'b1;
            end else if (i < BP_B) begin : g_loc
                assign raw_v[i]  = loc_irq[i-LOC_B];
                assign pol_v[i]  = loc_pol[i-LOC_B];
                assign edge_v[i] = loc_edge[i-LOC_B];
            end else begin : g_bp
                assign raw_v[i]  = bp_irq_n[i-BP_B];
                assign pol_v[i]  = 1'b0;
                assign edge_v[i] = 1'b0;
            end
            irq_src_cond u_cond (
                .clk       (clk),
                .rst       (rst),
                .raw       (raw_v[i]),
                .pol       (pol_v[i]),
                .edge_mode (edge_v[i]),
                .clr       (clr_v[i]),
                .pend      (pend_v[i])
            );
        end
    endgenerate

    assign eff_v = pend_v & ~src_mask;

    irq_prio_sel #(.N(N_SRC), .LW(LVL_W), .IW(SRC_W)) u_sel (
        .req     (eff_v),
        .lvl     (src_lvl),
        .sel_lvl (iack_lvl),
        .top_lvl (top_lvl),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign ipl_n = ~top_lvl;

    always_comb begin
        ack_clr = '0;
        if (iack && hit)
            ack_clr[hit_idx] = 1'b1;
    end
    assign clr_v = src_clr | ack_clr;

    always_comb begin
        rsp_d = '0;
        if (!hit) begin
            rsp_d.none = 1'b1;
        end else begin
            rsp_d.src = hit_idx;
            case (grp_of(int'(hit_idx)))
                GRP_ERR, GRP_IPC: begin
                    rsp_d.own = 1'b1;
                    rsp_d.vec = {int_vec_base, hit_idx};
                end
                GRP_LOC: begin
                    if (loc_vec_en[int'(hit_idx) - LOC_B]) begin
                        rsp_d.own = 1'b1;
                        rsp_d.vec = loc_vec[(int'(hit_idx) - LOC_B)*VEC_W +: VEC_W];
                    end
                end
                default: rsp_d.own = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else begin
            valid_q <= iack;
            rsp_q   <= iack ? rsp_d : '0;
        end
    end

    assign ack_valid = valid_q;
    assign ack_none  = rsp_q.none;
    assign ack_src   = rsp_q.src;
    assign ack_own   = rsp_q.own;
    assign ack_vec   = rsp_q.vec;
endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/100ps
module irq_prio_chk
    import irq_prio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_mask,
    input logic             iack,
    input logic [LVL_W-1:0] ipl_n,
    input logic             ack_valid,
    input logic             ack_none,
    input logic [SRC_W-1:0] ack_src,
    input logic             ack_own,
    input logic [VEC_W-1:0] ack_vec
);
    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (ipl_n == '1 && !ack_valid));

    // R2
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&src_mask) |-> (ipl_n == '1));

    // R7
    ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        iack |=> ack_valid);

    // R7
    no_stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !iack |=> !ack_valid);

    // R8
    none_is_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_none) |-> (ack_src == '0 && !ack_own && ack_vec == '0));

    // R9
    bp_no_own_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_none && int'(ack_src) >= BP_B) |-> (!ack_own && ack_vec == '0));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_mask  (src_mask),
    .iack      (iack),
    .ipl_n     (ipl_n),
    .ack_valid (ack_valid),
    .ack_none  (ack_none),
    .ack_src   (ack_src),
    .ack_own   (ack_own),
    .ack_vec   (ack_vec)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/100ps
module sim_irq_prio_ctrl;
    import irq_prio_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_BP-1:0]        bp_irq_n = '1;
    logic [N_LOC-1:0]       loc_irq = '0, loc_edge = '0, loc_pol = '1, loc_vec_en = '0;
    logic [N_ERR-1:0]       err_evt = '0;
    logic [N_IPC-1:0]       ipc_evt = '0;
    logic [N_LOC*VEC_W-1:0] loc_vec = '0;
    logic [VEC_W-SRC_W-1:0] int_vec_base = 3'b101;
    logic [N_SRC*LVL_W-1:0] src_lvl = '0;
    logic [N_SRC-1:0]       src_mask = '0, src_clr = '0;
    logic                   iack = 1'b0;
    logic [LVL_W-1:0]       iack_lvl = '0;
    logic [LVL_W-1:0]       ipl_n;
    logic                   ack_valid, ack_none, ack_own;
    logic [SRC_W-1:0]       ack_src;
    logic [VEC_W-1:0]       ack_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    ack_rsp_t exp_q[$];

    always #2.5 clk = ~clk;

    irq_prio_ctrl u0 (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_lvl(input int idx, input int v);
        src_lvl[idx*LVL_W +: LVL_W] = LVL_W'(v);
    endtask

    task automatic check_ipl(input logic [2:0] exp, input string req);
        checks++;
        if (ipl_n !== exp) begin
            errors++;
            $display("FAIL %s: ipl_n=%b expected %b", req, ipl_n, exp);
        end
    endtask

    // driver: push expected response, pulse the strobe for one cycle
    task automatic do_ack(input int lvl, input bit none, input int src,
                          input bit own, input int vec);
        ack_rsp_t e;
        e.none = none; e.src = SRC_W'(src); e.own = own; e.vec = VEC_W'(vec);
        exp_q.push_back(e);
        iack = 1'b1;
        iack_lvl = LVL_W'(lvl);
        tick();
        iack = 1'b0;
    endtask

    // monitor: compare each response against the queue
    always @(negedge clk) begin
        if (!rst && ack_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7: unexpected response src=%0d expected none queued", ack_src);
            end else begin
                ack_rsp_t e;
                e = exp_q.pop_front();
                if (ack_none !== e.none || ack_src !== e.src || ack_own !== e.own || ack_vec !== e.vec) begin
                    errors++;
                    $display("FAIL R7/R8/R9: got none=%b src=%0d own=%b vec=%h expected none=%b src=%0d own=%b vec=%h",
                             ack_none, ack_src, ack_own, ack_vec, e.none, e.src, e.own, e.vec);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R11 reset state
        check_ipl(3'b111, "R11");
        checks++;
        if (ack_valid !== 1'b0) begin errors++; $display("FAIL R11: ack_valid=%b expected 0", ack_valid); end

        // R5 backplane level tracking, R1 encoding (index 22, level 3)
        set_lvl(22, 3);
        bp_irq_n[2] = 1'b0;
        tick();
        check_ipl(3'b100, "R1");
        bp_irq_n[2] = 1'b1;
        tick();
        check_ipl(3'b111, "R5");

        // R4 error event latches (index 0, level 5)
        set_lvl(0, 5);
        err_evt[0] = 1'b1; tick();
        err_evt[0] = 1'b0; tick();
        check_ipl(3'b010, "R4");

        // R2 masking
        src_mask[0] = 1'b1; #0.1;
        check_ipl(3'b111, "R2");
        src_mask[0] = 1'b0; #0.1;
        check_ipl(3'b010, "R2");

        // R7 / R9 internal vector, latch cleared by acknowledge
        do_ack(5, 1'b0, 0, 1'b1, 8'hA0);
        check_ipl(3'b111, "R7");

        // R3 ties at level 4: ipc 6, local 13 (level mode, own vector), backplane 20
        set_lvl(6, 4); set_lvl(13, 4); set_lvl(20, 4);
        loc_vec_en[0] = 1'b1;
        loc_vec[7:0]  = 8'h3C;
        ipc_evt[1] = 1'b1; loc_irq[0] = 1'b1; bp_irq_n[0] = 1'b0;
        tick();
        ipc_evt[1] = 1'b0;
        check_ipl(3'b011, "R3");
        do_ack(4, 1'b0, 6, 1'b1, 8'hA6);
        do_ack(4, 1'b0, 13, 1'b1, 8'h3C);
        do_ack(4, 1'b0, 13, 1'b1, 8'h3C);   // R5 level source stays pending
        loc_irq[0] = 1'b0;
        tick();
        do_ack(4, 1'b0, 20, 1'b0, 0);       // R9 backplane: no own vector
        bp_irq_n[0] = 1'b1;
        tick();
        check_ipl(3'b111, "R5");

        // R8 empty level and level 0
        do_ack(6, 1'b1, 0, 1'b0, 0);
        do_ack(0, 1'b1, 0, 1'b0, 0);

        // R6 falling-edge local line (index 16), R10 explicit clear
        loc_irq[3] = 1'b1; loc_pol[3] = 1'b0; loc_edge[3] = 1'b1; src_clr[16] = 1'b1;
        tick();
        src_clr[16] = 1'b0; set_lvl(16, 7);
        tick();
        check_ipl(3'b111, "R6");
        loc_irq[3] = 1'b0;
        tick();
        check_ipl(3'b000, "R6");
        loc_irq[3] = 1'b1;
        tick();
        check_ipl(3'b000, "R4");
        src_clr[16] = 1'b1;
        tick();
        src_clr[16] = 1'b0;
        check_ipl(3'b111, "R10");

        // R6 active-low level local line (index 17)
        loc_irq[4] = 1'b1; loc_pol[4] = 1'b0; set_lvl(17, 2);
        tick();
        check_ipl(3'b111, "R6");
        loc_irq[4] = 1'b0;
        tick();
        check_ipl(3'b101, "R6");
        loc_irq[4] = 1'b1;
        tick();
        check_ipl(3'b111, "R5");

        // R1 highest level wins across groups
        set_lvl(1, 1); set_lvl(12, 6);
        err_evt[1] = 1'b1; ipc_evt[7] = 1'b1;
        tick();
        err_evt[1] = 1'b0; ipc_evt[7] = 1'b0;
        check_ipl(3'b001, "R1");
        do_ack(6, 1'b0, 12, 1'b1, 8'hAC);
        check_ipl(3'b110, "R1");
        do_ack(1, 1'b0, 1, 1'b1, 8'hA1);
        check_ipl(3'b111, "R7");

        tick();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R7: %0d responses missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule